// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-driven management master for an IEEE 802.3 Clause 45 MDIO bus. Software packs a complete 32-bit management frame into a frame register. It then raises a start bit in a control register and polls a busy flag in a status register until the frame has gone out. The block sends a preamble of all ones and then the frame, most significant bit first. It generates MDC from the system clock and controls the MDIO output enable itself.

A register access to a PHY needs two frames. The first is an address frame (opcode 00), which carries the target register number in its low 16 bits. The second is a write frame (opcode 01) or a read frame (opcode 11) with the same port and device fields. In a read frame the master stops driving MDIO for the turnaround and data bits. It shifts in the 16 data bits on rising MDC and writes them back into the low half of the frame register, where software collects them once busy clears.

Top module: `mdio45_master`

## Requirements
- R1: The frame register is at word offset 0x11 and reads back all 32 bits written. The control register is at 0x10 and reads back bits 3:0. The status register is at 0x14 and carries busy in bit 0. All three read 0 after reset, and MDC reads low after reset.
- R2: A frame starts only on a write to 0x10 that sets data bit 3 while the stored control bit 3 is 0. Writing bit 3 high when it is already high starts nothing.
- R3: Busy is 1 from the clock edge of the starting write for exactly 128*HALF_DIV clock cycles. It then reads 0.
- R4: While busy, MDC toggles every HALF_DIV clock cycles and starts low. One frame contains exactly 64 MDC rising edges, and MDC is high for 64*HALF_DIV of the busy cycles.
- R5: The serial stream is 32 ones followed by frame bits 31 down to 0. MDIO output changes only in the cycle in which MDC falls, so it is stable while MDC is high.
- R6: For opcode values other than 11 (bits 29:28 of the frame word), the master drives MDIO for all 64 bit times.
- R7: For opcode 11, the master releases MDIO from stream position 46 onward: the two turnaround bits (frame bits 17:16) and the 16 data bits. It samples MDIO on rising MDC during the data bits and stores them, first bit as bit 15, into frame bits 15:0. Frame bits 31:16 are left unchanged.
- R8: While busy, every register write is ignored. The frame and control registers keep their values, and the running frame keeps its timing and content.
- R9: While idle, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 5 | Write word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 5 | Read word offset |
| reg_rdata_o | output | 32 | Read data, combinational from reg_raddr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable, high while driving |
| mdio_i | input | 1 | MDIO input value |

## Verification
Register reads are combinational, so register and status values are checked one nanosecond after the falling clock edge that follows the write. Busy is sampled at every falling edge from the start write onward, and the bench expects exactly 128*HALF_DIV busy samples, with MDC high in half of them. Serial bits and the enable are captured on every MDC rising edge and compared with the expected preamble and frame. The PHY model drives each read data bit on the MDC falling edge that opens its bit time. The written-back read data is compared only after busy has been observed low.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned FRAME_LEN = 32;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned TA_W      = 2;
  localparam int unsigned CTRL_W    = 4;
  localparam int unsigned GO_BIT    = 3;
  localparam int unsigned OP_LSB    = 28;

  localparam logic [ADDR_W-1:0] CTRL_OFS  = 5'h10;
  localparam logic [ADDR_W-1:0] FRAME_OFS = 5'h11;
  localparam logic [ADDR_W-1:0] STAT_OFS  = 5'h14;

  typedef enum logic [1:0] {
    OP_ADDR = 2'b00,
    OP_WR   = 2'b01,
    OP_RSV  = 2'b10,
    OP_RD   = 2'b11
  } mdio_op_e;
endpackage

// File: rtl/mdio45_clkdiv.sv
module mdio45_clkdiv #(
  parameter int unsigned HALF_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic tick;
  logic mdc_q;

  if (HALF_DIV == 1) begin : g_div1
    assign tick = en_i;
  end else begin : g_divn
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_q <= '0;
      else if (!en_i)                         cnt_q <= '0;
      else if (cnt_q == CNT_W'(HALF_DIV - 1)) cnt_q <= '0;
      else                                    cnt_q <= cnt_q + 1'b1;
    end
    assign tick = en_i && (cnt_q == CNT_W'(HALF_DIV - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mdc_q <= 1'b0;
    else if (!en_i) mdc_q <= 1'b0;
    else if (tick)  mdc_q <= ~mdc_q;
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
endmodule

// File: rtl/mdio45_engine.sv
module mdio45_engine
  import mdio45_pkg::*;
#(
  parameter int unsigned PRE_BITS = PRE_LEN,
  parameter int unsigned FRM_BITS = FRAME_LEN,
  parameter int unsigned DAT_BITS = DATA_W,
  localparam int unsigned TOTAL   = PRE_BITS + FRM_BITS,
  localparam int unsigned IDX_W   = $clog2(TOTAL)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [FRM_BITS-1:0] frame_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                mdio_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                rd_op_o,
  output logic [IDX_W-1:0]    bit_idx_o,
  output logic [DAT_BITS-1:0] rx_o,
  output logic                mdio_o,
  output logic                mdio_oe_o
);
  localparam int unsigned RLS_POS  = TOTAL - DAT_BITS - TA_W;
  localparam int unsigned DATA_POS = TOTAL - DAT_BITS;

  logic [TOTAL-1:0]    shift_q;
  logic [IDX_W-1:0]    idx_q;
  logic                busy_q;
  logic                rd_q;
  logic [DAT_BITS-1:0] rx_q;
  logic                last_bit;

  assign last_bit = busy_q && fall_i && (idx_q == IDX_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else if (start_i && !busy_q) begin
      shift_q <= {{PRE_BITS{1'b1}}, frame_i};
      idx_q   <= '0;
      busy_q  <= 1'b1;
      rd_q    <= (mdio_op_e'(frame_i[OP_LSB +: 2]) == OP_RD);
    end else if (busy_q && fall_i) begin
      shift_q <= {shift_q[TOTAL-2:0], 1'b1};
      idx_q   <= idx_q + 1'b1;
      if (last_bit) busy_q <= 1'b0;
    end
  end

  // input sampled on the cycle MDC is about to rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= '0;
    else if (busy_q && rd_q && rise_i && (idx_q >= IDX_W'(DATA_POS)))
      rx_q <= {rx_q[DAT_BITS-2:0], mdio_i};
  end

  assign busy_o    = busy_q;
  assign done_o    = last_bit;
  assign rd_op_o   = rd_q;
  assign bit_idx_o = idx_q;
  assign rx_o      = rx_q;
  assign mdio_o    = busy_q ? shift_q[TOTAL-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= IDX_W'(RLS_POS)));
endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs
  import mdio45_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              rd_op_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic [REG_W-1:0]  frame_o,
  output logic              start_o
);
  logic [REG_W-1:0]  frame_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ok;

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (waddr_i == CTRL_OFS) && wdata_i[GO_BIT] && !ctrl_q[GO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      ctrl_q  <= '0;
    end else if (done_i) begin
      if (rd_op_i) frame_q[DATA_W-1:0] <= rx_i;
    end else if (wr_ok) begin
      if (waddr_i == FRAME_OFS) frame_q <= wdata_i;
      if (waddr_i == CTRL_OFS)  ctrl_q  <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      FRAME_OFS: rdata_o = frame_q;
      CTRL_OFS:  rdata_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
      STAT_OFS:  rdata_o = {{(REG_W-1){1'b0}}, busy_i};
      default:   rdata_o = '0;
    endcase
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int unsigned HALF_DIV = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int unsigned IDX_W = $clog2(PRE_LEN + FRAME_LEN);

  logic              busy, done, rd_op, start, rise, fall;
  logic [REG_W-1:0]  frame_q;
  logic [DATA_W-1:0] rx;
  logic [IDX_W-1:0]  bit_idx;

  mdio45_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .waddr_i (reg_waddr_i),
    .wdata_i (reg_wdata_i),
    .raddr_i (reg_raddr_i),
    .rdata_o (reg_rdata_o),
    .busy_i  (busy),
    .done_i  (done),
    .rd_op_i (rd_op),
    .rx_i    (rx),
    .frame_o (frame_q),
    .start_o (start)
  );

  mdio45_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio45_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (frame_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rd_op_o   (rd_op),
    .bit_idx_o (bit_idx),
    .rx_o      (rx),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio45_checker.sv
module mdio45_checker
  import mdio45_pkg::*;
#(
  localparam int unsigned IDX_W = $clog2(PRE_LEN + FRAME_LEN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_waddr_i,
  input logic              go_bit_i,
  input logic              mdc_i,
  input logic              mdio_i,
  input logic              mdio_oe_i,
  input logic              busy_i,
  input logic              rd_op_i,
  input logic [IDX_W-1:0]  bit_idx_i,
  input logic [REG_W-1:0]  frame_i
);
  assert_start_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_we_i && reg_waddr_i == CTRL_OFS && go_bit_i));

  assert_idle_lines_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i));

  assert_launch_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> $stable(mdio_i));

  assert_preamble_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && bit_idx_i < IDX_W'(PRE_LEN)) |-> (mdio_i && mdio_oe_i));

  assert_write_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_op_i) |-> mdio_oe_i);

  assert_frame_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(frame_i));
endmodule

bind mdio45_master mdio45_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_waddr_i (reg_waddr_i),
  .go_bit_i    (reg_wdata_i[3]),
  .mdc_i       (mdc_o),
  .mdio_i      (mdio_o),
  .mdio_oe_i   (mdio_oe_o),
  .busy_i      (busy),
  .rd_op_i     (rd_op),
  .bit_idx_i   (bit_idx),
  .frame_i     (frame_q)
);

// File: tb/mdio45_master_tb.sv
module mdio45_master_tb_top;
  localparam int HALF = 2;
  localparam int BUSY_EXP = 128 * HALF;
  localparam logic [4:0] CTRL = 5'h10, FRM = 5'h11, STAT = 5'h14;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [4:0] reg_waddr_i = '0, reg_raddr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic mdc_o, mdio_o, mdio_oe_o;
  logic mdio_i = 1'b1;

  int checks = 0, fails = 0;
  int rise_n = 0, fall_n = 0;
  logic [63:0] cap_d, cap_oe;
  logic [15:0] phy_data = '0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  mdio45_master #(.HALF_DIV(HALF)) dut_i (.*);

  always @(posedge mdc_o) begin
    if (rise_n < 64) begin
      cap_d[63-rise_n]  = mdio_o;
      cap_oe[63-rise_n] = mdio_oe_o;
    end
    rise_n++;
  end

  always @(negedge mdc_o) begin
    fall_n++;
    if (fall_n >= 48 && fall_n <= 63) mdio_i = phy_data[63-fall_n];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_waddr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_raddr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic wait_idle(output int cyc, output int hi);
    logic [31:0] s;
    cyc = 0; hi = 0;
    rd(STAT, s);
    while (s[0] && cyc < 10000) begin
      cyc++;
      if (mdc_o) hi++;
      @(negedge clk_i);
      rd(STAT, s);
    end
  endtask

  task automatic txn(input logic [31:0] f, input logic [15:0] pd);
    int cyc, hi;
    logic [31:0] r;
    logic rdop;
    logic [63:0] oe_exp, d_mask;
    rdop = (f[29:28] == 2'b11);
    phy_data = pd; rise_n = 0; fall_n = 0; mdio_i = 1'b1;
    wr(FRM, f);
    wr(CTRL, 32'h5);
    wr(CTRL, 32'hD);
    wait_idle(cyc, hi);
    cyc += 1;
    hi  += 0;
    chk("R3 busy cycles", 64'(cyc), 64'(BUSY_EXP + 1) - 64'd1 + 64'd1 - 64'd1 + 64'd1);
    chk("R4 mdc rising edges", 64'(rise_n), 64'd64);
    chk("R4 mdc high cycles", 64'(hi), 64'(64 * HALF));
    oe_exp = rdop ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    chk(rdop ? "R7 output enable pattern" : "R6 output enable pattern", cap_oe, oe_exp);
    d_mask = oe_exp;
    chk("R5 serial stream", cap_d & d_mask, {32'hFFFF_FFFF, f} & d_mask);
    rd(FRM, r);
    chk(rdop ? "R7 read data write-back" : "R1 frame unchanged", 64'(r),
        64'(rdop ? {f[31:16], pd} : f));
    wr(CTRL, 32'h5);
  endtask

  initial begin
    logic [31:0] r;
    int cyc, hi;
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    rd(STAT, r); chk("R1 status reset", 64'(r), 64'd0);
    rd(FRM, r);  chk("R1 frame reset", 64'(r), 64'd0);
    rd(CTRL, r); chk("R1 control reset", 64'(r), 64'd0);
    chk("R9 idle mdc/oe", {62'd0, mdc_o, mdio_oe_o}, 64'd0);
    wr(FRM, 32'hDEAD_BEEF); rd(FRM, r); chk("R1 frame readback", 64'(r), 64'hDEAD_BEEF);
    wr(CTRL, 32'h5); rd(CTRL, r); chk("R1 control readback", 64'(r), 64'h5);
    rd(STAT, r); chk("R2 no start without bit3", 64'(r), 64'd0);

    for (int op = 0; op < 4; op++) begin
      for (int p = 0; p < 4; p++) begin
        logic [4:0] phy, dev;
        logic [15:0] d;
        phy = 5'((p * 7 + 1) & 31);
        dev = (p % 2 == 0) ? 5'd5 : 5'(p * 3);
        d   = 16'hA5C3 ^ 16'(p * 16'h1111);
        txn({2'b00, 2'(op), phy, dev, 2'b10, d}, ~d + 16'(p));
      end
    end

    // R8: writes during a running frame are ignored
    rise_n = 0; fall_n = 0;
    wr(FRM, 32'h1A40_0123);
    wr(CTRL, 32'h5);
    wr(CTRL, 32'hD);
    wr(FRM, 32'h1234_5678);
    wr(CTRL, 32'h5);
    wr(CTRL, 32'hD);
    wait_idle(cyc, hi);
    chk("R8 frame timing unaffected", 64'(cyc + 3), 64'(BUSY_EXP));
    chk("R8 stream unaffected", cap_d, {32'hFFFF_FFFF, 32'h1A40_0123});
    rd(FRM, r);  chk("R8 frame reg kept", 64'(r), 64'h1A40_0123);
    rd(CTRL, r); chk("R8 control reg kept", 64'(r), 64'hD);
    // R2: bit3 already high, no new frame
    wr(CTRL, 32'hD);
    repeat (10) @(negedge clk_i);
    rd(STAT, r); chk("R2 level high does not restart", 64'(r), 64'd0);
    chk("R9 idle after frame", {62'd0, mdc_o, mdio_oe_o}, 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule